// File: doc/BRIEF.md
# Packed Word Dot-Product Accumulator

This block is a SIMD multiply-accumulate datapath. Each transfer carries a vector of 32-bit accumulator lanes and two vectors of 16-bit elements. For every output lane the block multiplies the two 16-bit elements of the first vector that sit inside that lane by the matching elements of the second vector. It then adds both products to that lane's accumulator. A 3-bit mode travels with the operands. It selects which operand is signed and whether the lane result wraps or clamps.

The lane count is a parameter, either 4 or 8. The result port is always eight lanes wide, and any lane above the active count reads zero. The operands enter through a valid/ready handshake, and the results leave through a second one after a pipeline whose depth is a parameter. When the consumer holds ready low, every stage of the pipeline stalls together, so results come out in the order the operands were accepted.

Top module: `wdot_acc`

## Requirements
- R1: Element k of each 16-bit operand vector occupies bits [16k+15:16k], and lane j occupies bits [32j+31:32j]. Lane j of the result is formed from elements 2j and 2j+1 of both operand vectors together with accumulator lane j.
- R2: When mode[1:0] is 2'b00, elements of `a_vec` are two's-complement and elements of `b_vec` are unsigned.
- R3: When mode[1:0] is 2'b01, elements of `a_vec` are unsigned and elements of `b_vec` are two's-complement.
- R4: When mode[1:0] is 2'b10 or 2'b11, both element vectors are unsigned, and the accumulator is read as an unsigned 32-bit value.
- R5: When mode[2] is 0, a lane result is the low 32 bits of the exact sum of the accumulator and both products, so any overflow wraps.
- R6: When mode[2] is 1 and mode[1:0] is 2'b00 or 2'b01, the accumulator is two's-complement. An exact sum above 2^31-1 gives 32'h7FFFFFFF, a sum below -2^31 gives 32'h80000000, and any other sum is passed through unchanged.
- R7: When mode[2] is 1 and mode[1:0] is 2'b10 or 2'b11, an exact sum above 2^32-1 gives 32'hFFFFFFFF, and any other sum is passed through unchanged.
- R8: Whenever `out_valid` is high, every bit of `out_data` at position LANES*32 or above is zero.
- R9: Results leave in acceptance order. While `out_ready` stays high, a transfer accepted at one rising edge is handed out at the edge STAGES cycles later.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` holds its value and `in_ready` is low. While `out_valid` is low, `in_ready` is high.
- R11: While `rst_n` is low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand transfer offered |
| in_ready | output | 1 | Operand transfer can be taken this cycle |
| mode | input | 3 | [1:0] signedness pairing, [2] saturation enable |
| acc_vec | input | LANES*32 | Accumulator lanes |
| a_vec | input | LANES*32 | First 16-bit element vector |
| b_vec | input | LANES*32 | Second 16-bit element vector |
| out_valid | output | 1 | Result transfer offered |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 256 | Result lanes, zero above LANES*32 |

## Verification
Two functions can fall in the same cycle: a lane clamps at one end of its range while its neighbour clamps at the other, and the consumer withholds ready while new operands are offered. The bench sends a transfer whose lanes alternate between positive and negative signed overflow. It then sends a random stream with extreme operands while ready is dropped at random. The scoreboard checks every lane against a 64-bit integer model. It also checks that a stalled result holds steady and that the offered operands are not taken until the stall clears.

// File: rtl/wdot_pkg.sv
package wdot_pkg;
    localparam int ELEM_W    = 16;
    localparam int LANE_W    = 32;
    localparam int MAX_LANES = 8;
    // exact three-term sum: 33-bit product range plus accumulator, with margin
    localparam int SUM_W     = 36;

    typedef enum logic [1:0] {
        PAIR_SU     = 2'b00,
        PAIR_US     = 2'b01,
        PAIR_UU     = 2'b10,
        PAIR_UU_ALT = 2'b11
    } pair_e;

    typedef struct packed {
        logic  sat;
        pair_e pair;
    } mode_t;
endpackage

// File: rtl/wdot_lane.sv
module wdot_lane
    import wdot_pkg::*;
(
    input  mode_t                 mode,
    input  logic [LANE_W-1:0]     acc,
    input  logic [2*ELEM_W-1:0]   a_pair,
    input  logic [2*ELEM_W-1:0]   b_pair,
    output logic [LANE_W-1:0]     res
);
    localparam int EXT_W  = ELEM_W + 1;
    localparam int PROD_W = 2 * EXT_W;
    localparam int PAD_P  = SUM_W - PROD_W;
    localparam int PAD_W  = SUM_W - LANE_W;

    localparam logic signed [SUM_W-1:0] SMAX = {{(PAD_W+1){1'b0}}, {(LANE_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] SMIN = {{(PAD_W+1){1'b1}}, {(LANE_W-1){1'b0}}};
    localparam logic signed [SUM_W-1:0] UMAX = {{PAD_W{1'b0}}, {LANE_W{1'b1}}};

    logic                     a_sgn, b_sgn, w_sgn;
    logic signed [EXT_W-1:0]  a_x [2];
    logic signed [EXT_W-1:0]  b_x [2];
    logic signed [PROD_W-1:0] prod [2];
    logic signed [SUM_W-1:0]  w_x;
    logic signed [SUM_W-1:0]  sum;

    always_comb begin
        a_sgn = (mode.pair == PAIR_SU);
        b_sgn = (mode.pair == PAIR_US);
        w_sgn = a_sgn | b_sgn;
        for (int i = 0; i < 2; i++) begin
            a_x[i]  = {a_sgn & a_pair[i*ELEM_W+ELEM_W-1], a_pair[i*ELEM_W +: ELEM_W]};
            b_x[i]  = {b_sgn & b_pair[i*ELEM_W+ELEM_W-1], b_pair[i*ELEM_W +: ELEM_W]};
            prod[i] = a_x[i] * b_x[i];
        end
        w_x = {{PAD_W{w_sgn & acc[LANE_W-1]}}, acc};
        sum = w_x
            + {{PAD_P{prod[0][PROD_W-1]}}, prod[0]}
            + {{PAD_P{prod[1][PROD_W-1]}}, prod[1]};
        res = sum[LANE_W-1:0];
        if (mode.sat) begin
            if (w_sgn) begin
                if (sum > SMAX)      res = SMAX[LANE_W-1:0];
                else if (sum < SMIN) res = SMIN[LANE_W-1:0];
            end else if (sum > UMAX) begin
                res = UMAX[LANE_W-1:0];
            end
        end
    end
endmodule

// File: rtl/wdot_pipe.sv
module wdot_pipe #(
    parameter int DATA_W = 128,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0]             vld;
        logic [STAGES-1:0][DATA_W-1:0] dat;
    } pipe_t;

    pipe_t st_d, st_q;
    logic  adv_d;

    always_comb begin
        adv_d = !st_q.vld[LAST] || out_ready;
        st_d  = st_q;
        if (adv_d) begin
            st_d.vld[0] = in_valid;
            st_d.dat[0] = in_data;
            for (int s = 1; s < STAGES; s++) begin
                st_d.vld[s] = st_q.vld[s-1];
                st_d.dat[s] = st_q.dat[s-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready  = adv_d;
    assign out_valid = st_q.vld[LAST];
    assign out_data  = st_q.dat[LAST];
endmodule

// File: rtl/wdot_acc.sv
module wdot_acc
    import wdot_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [2:0]                  mode,
    input  logic [LANES*LANE_W-1:0]     acc_vec,
    input  logic [LANES*LANE_W-1:0]     a_vec,
    input  logic [LANES*LANE_W-1:0]     b_vec,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [MAX_LANES*LANE_W-1:0] out_data
);
    localparam int VW    = LANES * LANE_W;
    localparam int DST_W = MAX_LANES * LANE_W;

    if (LANES != 4 && LANES != 8) begin : g_bad_lanes
        $error("wdot_acc: LANES must be 4 or 8");
    end

    mode_t         mode_s;
    logic [VW-1:0] lane_res;
    logic [VW-1:0] pipe_out;

    assign mode_s = mode_t'(mode);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        wdot_lane u_lane (
            .mode   (mode_s),
            .acc    (acc_vec[j*LANE_W +: LANE_W]),
            .a_pair (a_vec[j*LANE_W +: LANE_W]),
            .b_pair (b_vec[j*LANE_W +: LANE_W]),
            .res    (lane_res[j*LANE_W +: LANE_W])
        );
    end

    wdot_pipe #(.DATA_W(VW), .STAGES(STAGES)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (lane_res),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (pipe_out)
    );

    if (VW < DST_W) begin : g_pad
        assign out_data = {{(DST_W-VW){1'b0}}, pipe_out};
    end else begin : g_full
        assign out_data = pipe_out;
    end
endmodule

// File: rtl/wdot_acc_chk.sv
module wdot_acc_chk #(
    parameter int VW    = 128,
    parameter int DST_W = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [DST_W-1:0] out_data
);
    logic [15:0] inflight_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inflight_q <= '0;
        else        inflight_q <= inflight_q + 16'(in_valid && in_ready)
                                             - 16'(out_valid && out_ready);
    end

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data >> VW) == '0));                             // R8
    AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (inflight_q != 16'd0));                                // R9
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));     // R10
    AST_BLOCK_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);                            // R10
    AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);                                            // R10
endmodule

bind wdot_acc wdot_acc_chk #(.VW(LANES*32), .DST_W(256)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/wdot_acc_bench.sv
module wdot_acc_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int LANES      = 4;
    localparam int STAGES     = 2;
    localparam int VW         = LANES * 32;
    localparam int DST_W      = 256;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             out_ready = 1'b1;
    logic [2:0]       mode = 3'b000;
    logic [VW-1:0]    acc_vec = '0;
    logic [VW-1:0]    a_vec = '0;
    logic [VW-1:0]    b_vec = '0;
    wire              in_ready;
    wire              out_valid;
    wire [DST_W-1:0]  out_data;

    typedef struct {
        logic [DST_W-1:0] exp;
        int               cyc;
        string            tag;
        bit               timed;
    } item_t;

    item_t sb[$];
    int    errors = 0;
    int    checks = 0;
    int    cyc = 0;
    bit    bp_on = 1'b0;
    bit    done = 1'b0;

    wdot_acc #(.LANES(LANES), .STAGES(STAGES)) u_wdot_acc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .mode(mode), .acc_vec(acc_vec), .a_vec(a_vec), .b_vec(b_vec),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    always #HALF clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // 64-bit reference for one lane
    function automatic logic [31:0] lane_model(input logic [2:0] md, input logic [31:0] w,
                                               input logic [31:0] a, input logic [31:0] b);
        longint s, pa, pb;
        logic [15:0] ea, eb;
        bit sgn_w;
        sgn_w = (md[1:0] == 2'b00) || (md[1:0] == 2'b01);
        s = sgn_w ? longint'($signed(w)) : longint'({32'h0, w});
        for (int k = 0; k < 2; k++) begin
            ea = a[k*16 +: 16];
            eb = b[k*16 +: 16];
            pa = (md[1:0] == 2'b00) ? longint'($signed(ea)) : longint'({48'h0, ea});
            pb = (md[1:0] == 2'b01) ? longint'($signed(eb)) : longint'({48'h0, eb});
            s  = s + pa * pb;
        end
        if (!md[2]) return s[31:0];
        if (sgn_w) begin
            if (s > 64'sd2147483647)  return 32'h7FFFFFFF;
            if (s < -64'sd2147483648) return 32'h80000000;
            return s[31:0];
        end
        if (s > 64'sd4294967295) return 32'hFFFFFFFF;
        return s[31:0];
    endfunction

    function automatic logic [DST_W-1:0] vec_model(input logic [2:0] md, input logic [VW-1:0] w,
                                                   input logic [VW-1:0] a, input logic [VW-1:0] b);
        logic [DST_W-1:0] r;
        r = '0;
        for (int j = 0; j < LANES; j++)
            r[j*32 +: 32] = lane_model(md, w[j*32 +: 32], a[j*32 +: 32], b[j*32 +: 32]);
        return r;
    endfunction

    function automatic logic [VW-1:0] rep16(input logic [15:0] x);
        logic [VW-1:0] r;
        for (int k = 0; k < 2*LANES; k++) r[k*16 +: 16] = x;
        return r;
    endfunction

    function automatic logic [VW-1:0] rep32(input logic [31:0] x);
        logic [VW-1:0] r;
        for (int j = 0; j < LANES; j++) r[j*32 +: 32] = x;
        return r;
    endfunction

    function automatic logic [15:0] rnd_elem();
        case ($urandom_range(0, 5))
            0:       return 16'h8000;
            1:       return 16'hFFFF;
            2:       return 16'h7FFF;
            default: return 16'($urandom);
        endcase
    endfunction

    function automatic logic [31:0] rnd_acc();
        case ($urandom_range(0, 5))
            0:       return 32'h7FFFFFFF;
            1:       return 32'h80000000;
            2:       return 32'hFFFFFFFF;
            default: return $urandom;
        endcase
    endfunction

    // driver: offers one transfer, pushes its expectation once taken
    task automatic send(input logic [2:0] md, input logic [VW-1:0] w,
                        input logic [VW-1:0] a, input logic [VW-1:0] b, input string tag);
        item_t it;
        bit    took;
        @(negedge clk);
        in_valid = 1'b1;
        mode     = md;
        acc_vec  = w;
        a_vec    = a;
        b_vec    = b;
        took     = 1'b0;
        while (!took) begin
            #(HALF-1);
            took = in_ready;
            if (took) begin
                it.exp   = vec_model(md, w, a, b);
                it.cyc   = cyc;
                it.tag   = tag;
                it.timed = !bp_on;
                sb.push_back(it);
                @(posedge clk);
            end else begin
                @(posedge clk);
                @(negedge clk);
            end
        end
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // monitor: drives ready pattern, pops and compares results
    initial begin
        item_t            it;
        logic [DST_W-1:0] held;
        bit               was_held;
        bit               was_blocked;
        was_held = 1'b0;
        held = '0;
        forever begin
            @(negedge clk);
            out_ready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
            #(HALF-1);
            if (rst_n) begin
                if (was_held) begin
                    checks++;
                    if (!out_valid || out_data !== held) begin
                        errors++;
                        $display("FAIL R10: stalled result changed, got %h valid=%0b expected %h",
                                 out_data, out_valid, held);
                    end
                end
                was_blocked = out_valid && !out_ready;
                if (was_blocked) begin
                    checks++;
                    if (in_ready !== 1'b0) begin
                        errors++;
                        $display("FAIL R10: in_ready during stall, got %0b expected 0", in_ready);
                    end
                end
                was_held = was_blocked;
                held     = out_data;
                if (out_valid && out_ready) begin
                    if (sb.size() == 0) begin
                        checks++;
                        errors++;
                        $display("FAIL R9: unexpected result %h, expected none", out_data);
                    end else begin
                        it = sb.pop_front();
                        checks++;
                        if (out_data !== it.exp) begin
                            errors++;
                            $display("FAIL %s: got %h expected %h", it.tag, out_data, it.exp);
                        end
                        checks++;
                        if ((out_data >> VW) !== '0) begin
                            errors++;
                            $display("FAIL R8: upper bits got %h expected 0", out_data >> VW);
                        end
                        if (it.timed) begin
                            checks++;
                            if (cyc - it.cyc != STAGES) begin
                                errors++;
                                $display("FAIL R9: latency got %0d expected %0d",
                                         cyc - it.cyc, STAGES);
                            end
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R9: watchdog expired, got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] w, a, b;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R11: in reset got valid=%0b ready=%0b expected valid=0 ready=1",
                     out_valid, in_ready);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R11: after reset got valid=%0b expected 0", out_valid);
        end

        // R1: distinct elements per position expose any pairing slip
        for (int j = 0; j < LANES; j++) w[j*32 +: 32] = 32'(j * 1000 + 5);
        for (int k = 0; k < 2*LANES; k++) begin
            a[k*16 +: 16] = 16'(k + 1);
            b[k*16 +: 16] = 16'(10 * k + 3);
        end
        send(3'b010, w, a, b, "R1");
        send(3'b000, w, a, b, "R1");

        // R2: signed A, unsigned B
        send(3'b000, rep32(32'd0),   rep16(16'h8000), rep16(16'hFFFF), "R2");
        send(3'b000, rep32(32'd100), rep16(16'h0003), rep16(16'hFFF9), "R2");
        send(3'b000, rep32(32'd100), rep16(16'hFFFD), rep16(16'h0007), "R2");

        // R3: unsigned A, signed B
        send(3'b001, rep32(32'd0),  rep16(16'hFFFF), rep16(16'h8000), "R3");
        send(3'b001, rep32(32'd50), rep16(16'h0002), rep16(16'hFFFF), "R3");

        // R4: both unsigned, both encodings
        send(3'b010, rep32(32'd0), rep16(16'hFFFF), rep16(16'hFFFF), "R4");
        send(3'b011, rep32(32'd7), rep16(16'hFFFF), rep16(16'h8000), "R4");

        // R5: wrap in signed and unsigned pairings
        send(3'b000, rep32(32'h7FFFFFFF), rep16(16'h7FFF), rep16(16'hFFFF), "R5");
        send(3'b010, rep32(32'hFFFFFFFF), rep16(16'hFFFF), rep16(16'hFFFF), "R5");
        send(3'b001, rep32(32'h80000000), rep16(16'hFFFF), rep16(16'h8000), "R5");

        // R6: signed clamp at both ends, and pass-through inside range
        send(3'b100, rep32(32'h7FFFFFFF), rep16(16'h7FFF), rep16(16'hFFFF), "R6");
        send(3'b100, rep32(32'h80000000), rep16(16'h8000), rep16(16'hFFFF), "R6");
        send(3'b101, rep32(32'h80000000), rep16(16'hFFFF), rep16(16'h8000), "R6");
        send(3'b101, rep32(32'h7FFFFFFF), rep16(16'hFFFF), rep16(16'h7FFF), "R6");
        send(3'b100, rep32(32'd10),       rep16(16'hFFFE), rep16(16'h0003), "R6");
        for (int j = 0; j < LANES; j++) begin
            w[j*32 +: 32] = (j % 2 != 0) ? 32'h80000000 : 32'h7FFFFFFF;
            a[j*32 +: 32] = (j % 2 != 0) ? {2{16'h8000}} : {2{16'h7FFF}};
        end
        send(3'b100, w, a, rep16(16'hFFFF), "R6");

        // R7: unsigned clamp and unsigned accumulator view
        send(3'b110, rep32(32'hFFFFFFFF), rep16(16'hFFFF), rep16(16'hFFFF), "R7");
        send(3'b111, rep32(32'h80000000), rep16(16'hFFFF), rep16(16'hFFFF), "R7");
        send(3'b110, rep32(32'h80000000), rep16(16'h0001), rep16(16'h0001), "R7");
        send(3'b110, rep32(32'hFFFFFFFF), rep16(16'h0000), rep16(16'h0000), "R7");
        drain();

        // R9 and R10: random stream under random back-pressure
        bp_on = 1'b1;
        for (int n = 0; n < 300; n++) begin
            for (int j = 0; j < LANES; j++) w[j*32 +: 32] = rnd_acc();
            for (int k = 0; k < 2*LANES; k++) begin
                a[k*16 +: 16] = rnd_elem();
                b[k*16 +: 16] = rnd_elem();
            end
            send(3'($urandom_range(0, 7)), w, a, b, "R9");
        end
        drain();
        bp_on = 1'b0;
        drain();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule